// File: doc/BRIEF.md
# Aperture Remapping Page Table Unit

This block remaps bus addresses that land inside a fixed aperture window onto physical memory, one 4 KiB page at a time. It holds one table entry per aperture page. Each entry carries a valid flag and a physical page frame. A translation request either returns the physical address one cycle later or raises a fault.

Software never addresses the table directly. It goes through three 32-bit registers. A control register holds the global enable. A selector register latches the bus address of the entry to touch. A data port reads or commits the entry that the selector points at.

The global enable is a two-state machine, `XL_OFF` and `XL_ON`. A control write with bit 0 set takes the `OFF_TO_ON` transition. A control write with bit 0 clear takes the `ON_TO_OFF` transition. Any other cycle keeps the current state. While the machine is in `XL_OFF`, every translation faults.

Top module: `remap_unit`

## Requirements
- R1: After reset the unit is in `XL_OFF` and every entry reads as zero. A control register read returns 0, and a translation request faults.
- R2: Register offsets are control at 0x0, selector at 0x4 and data port at 0x8.
  - A control write with bit 0 = 1 enters `XL_ON`.
  - A control write with bit 0 = 0 enters `XL_OFF`.
  - A control read returns the state in bit 0, with all other bits zero.
- R3: A write to the data port commits the entry at index (selector − APER_BASE) >> 12. Only bit 31 (valid) and bits 30:12 (frame) are stored. A later read returns bits 11:0 as zero.
- R4: A read of the data port returns the entry selected by the selector. A read of the selector returns the latched bus address.
- R5: A translation request is answered exactly one cycle later with xl_rsp high. On a hit, xl_fault is 0 and xl_paddr = {1'b0, frame, bus address bits 11:0}.
- R6: While the unit is in `XL_OFF`, every translation request faults, even if its entry is valid.
- R7: Only addresses with APER_BASE ≤ address < APER_END translate. The first and last byte of the aperture translate, and an address at APER_END or below APER_BASE faults.
- R8: A request whose entry has bit 31 clear faults. Whenever xl_fault is 1, xl_paddr is 0.
- R9: When the selector lies outside the aperture, a data-port write changes no entry and a data-port read returns 0.
- R10: A data-port write and a translation of the same entry in the same cycle return the entry value from before the write. The next translation sees the new value.
- R11: reg_rdata carries the read result in the cycle after reg_re and is 0 in any other cycle. Offsets other than 0x0, 0x4 and 0x8 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_off | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | Bus address to translate |
| xl_rsp | output | 1 | Translation response strobe |
| xl_fault | output | 1 | Translation fault |
| xl_paddr | output | 32 | Translated physical address, zero on fault |

## Verification
A wrong enable state is visible on the very next translation response, as an unexpected fault or an unexpected hit, and on the next control read. A corrupted or misindexed entry shows up one cycle after a translation or a data-port read of that page. The bench therefore probes the first and last aperture pages, the page that an out-of-range selector would wrap onto, and a page written in the same cycle it is translated. Any error in the response pipeline shows as a missing or extra xl_rsp strobe one cycle after the request.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_W    = 31 - PAGE_SHIFT;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_SEL  = 4'h4;
    localparam logic [3:0] OFF_DATA = 4'h8;

    typedef enum logic {
        XL_OFF = 1'b0,
        XL_ON  = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } entry_t;
endpackage

// File: rtl/remap_regs.sv
module remap_regs
    import remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter logic [31:0] APER_END  = 32'h5804_0000,
    parameter int          IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [3:0]       reg_off,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  entry_t           sel_entry,
    output logic [IDX_W-1:0] sel_idx,
    output logic             tbl_we,
    output entry_t           tbl_wentry,
    output logic             xl_on
);
    xl_state_e   state_q, state_d;
    logic [31:0] sel_q;
    logic [31:0] sel_rel;
    logic        sel_in;
    logic        ctrl_wr;

    assign ctrl_wr = reg_we && (reg_off == OFF_CTRL);
    assign sel_in  = (sel_q >= APER_BASE) && (sel_q < APER_END);
    assign sel_rel = sel_q - APER_BASE;
    assign sel_idx = sel_rel[PAGE_SHIFT +: IDX_W];

    // Next-state logic for the enable machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XL_OFF: if (ctrl_wr && reg_wdata[0])  state_d = XL_ON;   // OFF_TO_ON
            XL_ON:  if (ctrl_wr && !reg_wdata[0]) state_d = XL_OFF;  // ON_TO_OFF
            default: state_d = XL_OFF;
        endcase
    end

    // State register and selector latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XL_OFF;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (reg_we && (reg_off == OFF_SEL))
                sel_q <= reg_wdata;
        end
    end

    // Outputs
    assign xl_on            = (state_q == XL_ON);
    assign tbl_we           = reg_we && (reg_off == OFF_DATA) && sel_in;
    assign tbl_wentry.valid = reg_wdata[31];
    assign tbl_wentry.frame = reg_wdata[30:PAGE_SHIFT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            unique case (reg_off)
                OFF_CTRL: reg_rdata <= {31'b0, xl_on};
                OFF_SEL:  reg_rdata <= sel_q;
                OFF_DATA: reg_rdata <= sel_in ? {sel_entry.valid, sel_entry.frame, {PAGE_SHIFT{1'b0}}} : '0;
                default:  reg_rdata <= '0;
            endcase
        end else begin
            reg_rdata <= '0;
        end
    end
endmodule

// File: rtl/remap_table.sv
module remap_table
    import remap_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  entry_t           wentry,
    input  logic [IDX_W-1:0] ridx_a,
    output entry_t           rd_a,
    input  logic [IDX_W-1:0] ridx_b,
    output entry_t           rd_b
);
    entry_t mem [N_ENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) mem[i] <= '0;
        end else if (we && (int'(widx) < N_ENT)) begin
            mem[widx] <= wentry;
        end
    end

    assign rd_a = (int'(ridx_a) < N_ENT) ? mem[ridx_a] : '0;
    assign rd_b = (int'(ridx_b) < N_ENT) ? mem[ridx_b] : '0;
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter logic [31:0] APER_END  = 32'h5804_0000,
    parameter int          IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xl_on,
    input  logic             xl_req,
    input  logic [31:0]      xl_addr,
    output logic [IDX_W-1:0] idx,
    input  entry_t           entry,
    output logic             xl_rsp,
    output logic             xl_fault,
    output logic [31:0]      xl_paddr
);
    logic [31:0] rel;
    logic        in_rng;
    logic        hit;

    assign in_rng = (xl_addr >= APER_BASE) && (xl_addr < APER_END);
    assign rel    = xl_addr - APER_BASE;
    assign idx    = rel[PAGE_SHIFT +: IDX_W];
    assign hit    = xl_on && in_rng && entry.valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_rsp   <= 1'b0;
            xl_fault <= 1'b0;
            xl_paddr <= '0;
        end else begin
            xl_rsp   <= xl_req;
            xl_fault <= xl_req && !hit;
            xl_paddr <= (xl_req && hit) ? {1'b0, entry.frame, xl_addr[PAGE_SHIFT-1:0]} : '0;
        end
    end
endmodule

// File: rtl/remap_unit.sv
module remap_unit
    import remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter logic [31:0] APER_END  = 32'h5804_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [3:0]  reg_off,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        xl_req,
    input  logic [31:0] xl_addr,
    output logic        xl_rsp,
    output logic        xl_fault,
    output logic [31:0] xl_paddr
);
    localparam int N_ENT = int'((APER_END - APER_BASE) >> PAGE_SHIFT);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    entry_t           sel_entry, xl_entry, tbl_wentry;
    logic [IDX_W-1:0] sel_idx, xl_idx;
    logic             tbl_we;
    logic             xlate_en;

    remap_regs #(.APER_BASE(APER_BASE), .APER_END(APER_END), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel_entry(sel_entry),
        .sel_idx(sel_idx), .tbl_we(tbl_we), .tbl_wentry(tbl_wentry), .xl_on(xlate_en)
    );

    remap_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(sel_idx), .wentry(tbl_wentry),
        .ridx_a(sel_idx), .rd_a(sel_entry), .ridx_b(xl_idx), .rd_b(xl_entry)
    );

    remap_xlate #(.APER_BASE(APER_BASE), .APER_END(APER_END), .IDX_W(IDX_W)) u_xlate (
        .clk(clk), .rst_n(rst_n), .xl_on(xlate_en), .xl_req(xl_req), .xl_addr(xl_addr),
        .idx(xl_idx), .entry(xl_entry), .xl_rsp(xl_rsp), .xl_fault(xl_fault),
        .xl_paddr(xl_paddr)
    );
endmodule

// File: rtl/remap_unit_chk.sv
module remap_unit_chk #(
    parameter logic [31:0] APER_BASE = 32'h5800_0000,
    parameter logic [31:0] APER_END  = 32'h5804_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_re,
    input logic [31:0] reg_rdata,
    input logic        xl_req,
    input logic [31:0] xl_addr,
    input logic        xl_rsp,
    input logic        xl_fault,
    input logic [31:0] xl_paddr,
    input logic        xlate_en
);
    a_r5_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> xl_rsp);
    a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> !xl_rsp);
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_rsp && !xl_fault) |-> (xl_paddr[11:0] == $past(xl_addr[11:0])));
    a_r6_off_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !xlate_en) |=> xl_fault);
    a_r7_outside_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && ((xl_addr < APER_BASE) || (xl_addr >= APER_END))) |=> xl_fault);
    a_r8_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (xl_paddr == 32'h0));
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> (reg_rdata == 32'h0));
endmodule

bind remap_unit remap_unit_chk #(.APER_BASE(APER_BASE), .APER_END(APER_END)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .xl_req(xl_req), .xl_addr(xl_addr), .xl_rsp(xl_rsp), .xl_fault(xl_fault),
    .xl_paddr(xl_paddr), .xlate_en(xlate_en)
);

// File: tb/remap_unit_test.sv
module remap_unit_test;
    localparam logic [31:0] BASE = 32'h5800_0000;
    localparam logic [31:0] ENDA = 32'h5804_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xl_rsp, xl_fault;
    logic [31:0] xl_paddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    remap_unit #(.APER_BASE(BASE), .APER_END(ENDA)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_req(xl_req), .xl_addr(xl_addr),
        .xl_rsp(xl_rsp), .xl_fault(xl_fault), .xl_paddr(xl_paddr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_off = off;
        @(negedge clk);
        d = reg_rdata;
        reg_re = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] a, output logic rsp, output logic flt, output logic [31:0] pa);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = a;
        @(negedge clk);
        rsp = xl_rsp; flt = xl_fault; pa = xl_paddr;
        xl_req = 1'b0;
    endtask

    task automatic expect_hit(input logic [31:0] a, input logic [31:0] exp_pa, input string req);
        logic r, f; logic [31:0] p;
        xlate(a, r, f, p);
        check(r && !f && p == exp_pa, req, p, exp_pa);
    endtask

    task automatic expect_fault(input logic [31:0] a, input string req);
        logic r, f; logic [31:0] p;
        xlate(a, r, f, p);
        check(r && f && p == 32'h0, req, {f, p[30:0]}, 32'h8000_0000);
    endtask

    task automatic map_page(input int pg, input logic [31:0] d);
        reg_write(4'h4, BASE + 32'(pg) * 32'h1000);
        reg_write(4'h8, d);
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        reg_read(4'h0, d);
        check(d == 32'h0, "R1 ctrl after reset", d, 32'h0);
        reg_write(4'h4, BASE + 32'h3000);
        reg_read(4'h8, d);
        check(d == 32'h0, "R1 entry zero after reset", d, 32'h0);
        expect_fault(BASE + 32'h3000, "R1 fault after reset");
    endtask

    task automatic t_enable;
        logic [31:0] d;
        reg_write(4'h0, 32'h1);
        reg_read(4'h0, d);
        check(d == 32'h1, "R2 ctrl reads on", d, 32'h1);
    endtask

    task automatic t_write_readback;
        logic [31:0] d;
        map_page(3, 32'h9234_5ABC);
        reg_read(4'h8, d);
        check(d == 32'h9234_5000, "R3 entry stored, low bits zero", d, 32'h9234_5000);
        reg_read(4'h4, d);
        check(d == BASE + 32'h3000, "R4 selector readback", d, BASE + 32'h3000);
        reg_read(4'hC, d);
        check(d == 32'h0, "R11 unmapped offset", d, 32'h0);
    endtask

    task automatic t_hit;
        expect_hit(BASE + 32'h3456, 32'h1234_5456, "R5 hit page 3");
        map_page(0, 32'h80AA_A000);
        map_page(63, 32'h87FF_F000);
        expect_hit(BASE, 32'h00AA_A000, "R7 first byte");
        expect_hit(ENDA - 1, 32'h07FF_FFFF, "R7 last byte");
    endtask

    task automatic t_range;
        expect_fault(ENDA, "R7 end address");
        expect_fault(BASE - 1, "R7 below base");
    endtask

    task automatic t_invalid;
        expect_fault(BASE + 32'hA010, "R8 never-written page");
        map_page(3, 32'h0000_0000);
        expect_fault(BASE + 32'h3456, "R8 unmapped page");
    endtask

    task automatic t_outside_selector;
        logic [31:0] d;
        reg_write(4'h4, ENDA);
        reg_write(4'h8, 32'h8FFF_F000);
        reg_read(4'h8, d);
        check(d == 32'h0, "R9 read outside aperture", d, 32'h0);
        reg_write(4'h4, BASE);
        reg_read(4'h8, d);
        check(d == 32'h80AA_A000, "R9 page 0 untouched", d, 32'h80AA_A000);
    endtask

    task automatic t_same_cycle;
        map_page(5, 32'h8011_1000);
        @(negedge clk);
        reg_we = 1'b1; reg_off = 4'h8; reg_wdata = 32'h8022_2000;
        xl_req = 1'b1; xl_addr = BASE + 32'h5010;
        @(negedge clk);
        reg_we = 1'b0; xl_req = 1'b0;
        check(xl_rsp && !xl_fault && xl_paddr == 32'h0011_1010, "R10 old value", xl_paddr, 32'h0011_1010);
        expect_hit(BASE + 32'h5010, 32'h0022_2010, "R10 new value next");
    endtask

    task automatic t_disable;
        logic [31:0] d;
        reg_write(4'h0, 32'h0);
        reg_read(4'h0, d);
        check(d == 32'h0, "R2 ctrl reads off", d, 32'h0);
        expect_fault(BASE + 32'h5010, "R6 valid entry faults when off");
        reg_write(4'h0, 32'h1);
        expect_hit(BASE + 32'h5010, 32'h0022_2010, "R6 back on");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_enable();
        t_write_readback();
        t_hit();
        t_range();
        t_invalid();
        t_outside_selector();
        t_same_cycle();
        t_disable();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
            finish_run();
        end
    end
endmodule